// File: doc/BRIEF.md
# Store-Snooping Display Mirror

This block holds a register copy of the bottom 128 words of a processor's data memory and offers one chosen word, together with its index, to an external character-display driver. It does not own a frame buffer of its own. It sits beside the store path between processor and data memory and captures every store whose word address lies in the mirrored range. As a result, a program puts something on the display just by storing to one of those low addresses.

A 7-bit switch bank picks the location to show. The switch value is asynchronous to the clock, so it passes through a two-flop synchroniser before it is used. The selected entry is then registered onto the display outputs, together with the index it came from. A separate combinational read port exposes any entry, so a test environment can compare the whole mirror against a reference memory model.

The store port only watches traffic. It has an enable and no ready, so it never applies back-pressure: every enabled store is taken in the cycle it is presented. The display outputs are levels that are always valid, with no handshake. The rate at which the driver samples them is its own business.

Top module: `display_mirror`

## Requirements
- R1: Reset (rst_n low, synchronous) clears all 128 entries to zero and sets disp_word and disp_idx to zero.
- R2: A store with st_en high and st_addr below 128 writes st_data into entry st_addr[6:0] at that rising edge. This is the same edge that writes data memory, and rd_data shows the new word right after that edge.
- R3: A store with st_addr of 128 or more changes no entry, including the entry whose index equals its low seven bits, and leaves the display unchanged.
- R4: With st_en low, st_addr and st_data have no effect on any entry.
- R5: rd_data equals entry rd_addr combinationally, in the same cycle, with no register in the path.
- R6: A new sw_sel value held steady is reflected on disp_idx, and its entry on disp_word, after the third rising edge: two synchroniser stages, then the display register. After only two edges the old selection is still shown.
- R7: A store to the entry currently displayed appears on disp_word after the second rising edge counted from the write edge. That is one cycle after the entry itself changes.
- R8: disp_idx always names the entry whose contents disp_word shows, because both are loaded by the same register stage.
- R9: Repeated stores to one address leave the last data. A store to one address leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| st_en | input | 1 | Processor store enable (data memory write strobe) |
| st_addr | input | 12 | Word address of the store |
| st_data | input | 32 | Data being stored |
| sw_sel | input | 7 | Switch selection of the displayed entry, asynchronous |
| rd_addr | input | 7 | Entry index for the inspection read port |
| rd_data | output | 32 | Entry contents at rd_addr, combinational |
| disp_word | output | 32 | Registered word shown on the display |
| disp_idx | output | 7 | Registered index of the word shown |

## Verification
Each result has its own latency. An entry update is visible on rd_data one edge after the store. A change to the displayed entry reaches disp_word two edges after the store. A switch change reaches disp_idx and disp_word three edges after it is applied. The bench drives inputs on the falling edge and samples 1 ns after the rising edge whose count matches the result being checked. It also samples one edge early in the switch and display-write cases, to confirm that the old value is still held there.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  localparam int unsigned MIR_DEPTH_DEF = 128;
  localparam int unsigned MIR_WORD_W_DEF = 32;
  localparam int unsigned MIR_ADDR_W_DEF = 12;
  localparam int unsigned MIR_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    AGE_RESET = 2'd0,
    AGE_ONE   = 2'd1,
    AGE_TWO   = 2'd2,
    AGE_READY = 2'd3
  } age_t;
endpackage

// File: rtl/mirror_sync.sv
module mirror_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mirror_store.sv
module mirror_store #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [WORD_W-1:0] st_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  view_idx,
  output logic [WORD_W-1:0] view_data
);
  logic [WORD_W-1:0] entry [DEPTH];
  logic              in_range;
  logic              wr_hit;
  logic [IDX_W-1:0]  wr_idx;

  // Range decode: the store lands in the mirror only if every bit above the index is zero.
  if (ADDR_W > IDX_W) begin : g_range_cut
    assign in_range = (st_addr[ADDR_W-1:IDX_W] == '0);
  end else begin : g_range_all
    assign in_range = 1'b1;
  end

  assign wr_idx = st_addr[IDX_W-1:0];
  assign wr_hit = st_en && in_range;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                                entry[i] <= '0;
      else if (wr_hit && (wr_idx == IDX_W'(i)))  entry[i] <= st_data;
    end
  end

  assign rd_data   = entry[rd_addr];
  assign view_data = entry[view_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_hit) && rd_addr == $past(wr_idx)) |-> rd_data == $past(st_data)); // R2

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_hit) && $stable(rd_addr)) |-> $stable(rd_data)); // R3
endmodule

// File: rtl/mirror_view.sv
module mirror_view #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [WORD_W-1:0] sel_word,
  output logic [WORD_W-1:0] disp_word,
  output logic [IDX_W-1:0]  disp_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_word <= '0;
      disp_idx  <= '0;
    end else begin
      disp_word <= sel_word;
      disp_idx  <= sel_idx;
    end
  end
endmodule

// File: rtl/display_mirror.sv
module display_mirror
  import mirror_pkg::*;
#(
  parameter int unsigned DEPTH  = MIR_DEPTH_DEF,
  parameter int unsigned WORD_W = MIR_WORD_W_DEF,
  parameter int unsigned ADDR_W = MIR_ADDR_W_DEF,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [WORD_W-1:0] st_data,
  input  logic [IDX_W-1:0]  sw_sel,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] disp_word,
  output logic [IDX_W-1:0]  disp_idx
);
  logic [IDX_W-1:0]  sel_sync;
  logic [WORD_W-1:0] sel_word;

  mirror_sync #(.WIDTH(IDX_W), .STAGES(MIR_SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sw_sel),
    .sync_out (sel_sync)
  );

  mirror_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_en     (st_en),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .view_idx  (sel_sync),
    .view_data (sel_word)
  );

  mirror_view #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_view (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_idx   (sel_sync),
    .sel_word  (sel_word),
    .disp_word (disp_word),
    .disp_idx  (disp_idx)
  );

  // Cycles since reset, used only to qualify the latency checks below.
  age_t age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                 age_q <= AGE_RESET;
    else if (age_q != AGE_READY) age_q <= age_t'(age_q + 2'd1);
  end

  logic port_hit;
  assign port_hit = st_en && (st_addr < ADDR_W'(DEPTH));

  AST_SWITCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_READY) |-> disp_idx == $past(sw_sel, 3)); // R6

  AST_DISPLAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_READY && $past(port_hit, 2) &&
     disp_idx == $past(st_addr[IDX_W-1:0], 2)) |-> disp_word == $past(st_data, 2)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(!rst_n) |-> (disp_word == '0 && disp_idx == '0)); // R1
endmodule

// File: tb/test_display_mirror.sv
module test_display_mirror;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_en;
  logic [11:0] st_addr;
  logic [31:0] st_data;
  logic [6:0]  sw_sel;
  logic [6:0]  rd_addr;
  logic [31:0] rd_data;
  logic [31:0] disp_word;
  logic [6:0]  disp_idx;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  display_mirror i_display_mirror (
    .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
    .sw_sel(sw_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .disp_word(disp_word), .disp_idx(disp_idx)
  );

  // Vector: {en, addr[11:0], data[31:0], chk_idx[6:0], expected[31:0]}
  localparam int NV = 9;
  localparam logic [83:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h1111_1111, 7'h00, 32'h1111_1111},  // R2 bottom
    {1'b1, 12'h07F, 32'hDEAD_BEEF, 7'h7F, 32'hDEAD_BEEF},  // R2 top
    {1'b1, 12'h080, 32'h5555_5555, 7'h00, 32'h1111_1111},  // R3 alias of 0
    {1'b1, 12'h0FF, 32'h6666_6666, 7'h7F, 32'hDEAD_BEEF},  // R3 alias of 127
    {1'b0, 12'h005, 32'h7777_7777, 7'h05, 32'h0000_0000},  // R4
    {1'b1, 12'h005, 32'h1234_5678, 7'h05, 32'h1234_5678},  // R2
    {1'b1, 12'h005, 32'h9ABC_DEF0, 7'h05, 32'h9ABC_DEF0},  // R9 last wins
    {1'b1, 12'h040, 32'h0BAD_F00D, 7'h05, 32'h9ABC_DEF0},  // R9 independent
    {1'b1, 12'hFFF, 32'hFFFF_FFFF, 7'h40, 32'h0BAD_F00D}   // R3 top alias
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_en = 1'b0; st_addr = '0; st_data = '0; sw_sel = '0; rd_addr = '0;
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    // R1: reset state
    check("R1 disp_word", disp_word, 32'h0);
    check("R1 disp_idx", {25'h0, disp_idx}, 32'h0);
    for (int i = 0; i < 128; i += 37) begin
      rd_addr = 7'(i);
      #0.5;
      check("R1 entry", rd_data, 32'h0);
    end

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      st_en   = VEC[v][83];
      st_addr = VEC[v][82:71];
      st_data = VEC[v][70:39];
      rd_addr = VEC[v][38:32];
      edges(1);
      st_en = 1'b0;
      check($sformatf("R2/R3/R4/R9 vector %0d", v), rd_data, VEC[v][31:0]);
    end

    // R5: combinational read, no clock edge needed
    @(negedge clk);
    rd_addr = 7'h7F; #0.5;
    check("R5 read 7F", rd_data, 32'hDEAD_BEEF);
    rd_addr = 7'h40; #0.5;
    check("R5 read 40", rd_data, 32'h0BAD_F00D);

    // R6: switch latency
    @(negedge clk) sw_sel = 7'h7F;
    edges(2);
    check("R6 old idx after 2 edges", {25'h0, disp_idx}, 32'h0);
    edges(1);
    check("R6 new idx after 3 edges", {25'h0, disp_idx}, 32'h7F);
    check("R8 word matches idx", disp_word, 32'hDEAD_BEEF);

    // R7: write to displayed entry
    @(negedge clk) begin st_en = 1'b1; st_addr = 12'h07F; st_data = 32'hCAFE_F00D; end
    edges(1);
    st_en = 1'b0;
    check("R7 old word after 1 edge", disp_word, 32'hDEAD_BEEF);
    edges(1);
    check("R7 new word after 2 edges", disp_word, 32'hCAFE_F00D);

    // R3: out-of-range store aliasing the displayed index leaves display
    @(negedge clk) begin st_en = 1'b1; st_addr = 12'h17F; st_data = 32'h0000_0BAD; end
    edges(1);
    st_en = 1'b0;
    edges(2);
    check("R3 display unchanged", disp_word, 32'hCAFE_F00D);

    // R6/R8: switch to another entry
    @(negedge clk) sw_sel = 7'h05;
    edges(3);
    check("R6 idx 05", {25'h0, disp_idx}, 32'h05);
    check("R8 word at 05", disp_word, 32'h9ABC_DEF0);

    // R1: reset in mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    edges(1);
    @(negedge clk) rst_n = 1'b1;
    rd_addr = 7'h05; #0.5;
    check("R1 entry cleared", rd_data, 32'h0);
    check("R1 disp cleared", disp_word, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule